// File: doc/BRIEF.md
# Serial Start-Bit Channel Configurator

This block is the command front end of a serial analogue-to-digital converter. While an active-low chip select is held low, it samples a serial data line on each rising edge of the serial clock. It skips any leading zeros until it sees a logic 1 start bit. It then gathers a short configuration word and turns it into analogue multiplexer enables: a one-hot select for the positive converter input, and a one-hot select for the negative input. The negative input is either a channel or the shared reference terminal, which is ground on the four-channel build and the common input on the eight-channel build.

After the last configuration bit is captured, the selects are latched and a one-cycle start pulse goes to the conversion sequencer. The block then ignores the data line until chip select rises. A high chip select clears everything, including a word that was only partly received. The channel count is a parameter, either 4 or 8, and it sets the number of channel-select bits.

Top module: `adc_cfg_port`

## Requirements
- R1: A transaction is accepted only after the block has seen chip select high and then low. If chip select is already low when reset is released, the data line is not decoded, and the selects and start pulse stay at zero.
- R2: While chip select is low and no start bit has been seen, data bits of 0 are skipped, for any count of them.
- R3: After the start bit, exactly 2 + log2(N/2) bits are taken, in this order: mode (1 = single-ended, 0 = differential), then the odd/sign bit, then the channel-select bits with the most significant first. N=4 uses 3 bits and N=8 uses 4.
- R4: In single-ended mode the positive select has bit {select, odd} set. The negative select has only its top bit (index N, the reference terminal) set.
- R5: In differential mode, with pair k taken from the select bits, the positive select is channel 2k+odd and the negative select is channel 2k+(1-odd).
- R6: The selects take their decoded value right after the rising edge that captures the last configuration bit. The start pulse is high for exactly one cycle, one cycle after that edge, and occurs once per completed configuration.
- R7: Once the configuration is complete, further data bits have no effect on the selects and produce no further start pulse until chip select rises.
- R8: A rising edge with chip select high clears the selects, the start pulse and any partly received configuration. A following transaction decodes from a fresh start.
- R9: Each select is one-hot or zero at all times, and the positive and negative selects never name the same channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock; the data line is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip select |
| di_i | input | 1 | Serial data input |
| pos_sel_o | output | N | One-hot positive-input channel select |
| neg_sel_o | output | N+1 | One-hot negative-input select; bit N is the reference terminal |
| conv_start_o | output | 1 | One-cycle conversion start pulse |

## Verification
Every bit the bench drives is captured on the next rising edge. The selects must be valid at the falling edge right after the edge that takes the last configuration bit. The start pulse must be seen at the falling edge one cycle later and must be gone on the next one. A clear requested by raising chip select must show as all-zero outputs at the first falling edge after the next rising edge. The driver queues the expected select pair and checks the immediate select timing itself. The monitor pops the queue only when it sees the start pulse at a falling edge, so a pulse that comes late, repeats, or has no matching transaction is reported.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_CFG  = 2'd2,
    ST_HOLD = 2'd3
  } cfg_state_e;
endpackage

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o,
  output logic         last_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     word_q;
  logic [CNT_W-1:0] cnt_q;

  // word including the bit being captured this edge
  assign word_o = {word_q[W-2:0], bit_i};
  assign last_o = en_i && (cnt_q == CNT_W'(W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (en_i) begin
      word_q <= word_o;
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mux_decode.sv
module mux_decode #(
  parameter int N = 8
) (
  input  logic [1+$clog2(N)-1:0] cfg_i,
  output logic [N-1:0]           pos_o,
  output logic [N:0]             neg_o
);
  localparam int ID_W = $clog2(N);
  localparam int CW   = 1 + ID_W;

  logic            sgl;
  logic            odd;
  logic [ID_W-1:0] pos_id;
  logic [ID_W-1:0] neg_id;

  assign sgl = cfg_i[CW-1];
  assign odd = cfg_i[CW-2];

  generate
    if (ID_W > 1) begin : g_multi
      assign pos_id = {cfg_i[ID_W-2:0], odd};
      assign neg_id = {cfg_i[ID_W-2:0], ~odd};
    end else begin : g_single
      assign pos_id = odd;
      assign neg_id = ~odd;
    end
  endgenerate

  always_comb begin
    pos_o = '0;
    neg_o = '0;
    pos_o[pos_id] = 1'b1;
    if (sgl) neg_o[N] = 1'b1;
    else     neg_o[neg_id] = 1'b1;
  end
endmodule

// File: rtl/adc_cfg_port.sv
module adc_cfg_port #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_ni,
  input  logic         di_i,
  output logic [N-1:0] pos_sel_o,
  output logic [N:0]   neg_sel_o,
  output logic         conv_start_o
);
  import adc_cfg_pkg::*;

  localparam int ID_W = $clog2(N);
  localparam int CW   = 1 + ID_W;  // mode + odd + (ID_W-1) select bits

  cfg_state_e   state_q;
  logic         cs_q;
  logic         pend_q;
  logic         start_q;
  logic [N-1:0] pos_q;
  logic [N:0]   neg_q;

  logic [CW-1:0] cfg_word;
  logic          cfg_last;
  logic [N-1:0]  dec_pos;
  logic [N:0]    dec_neg;
  logic          shift_en;

  assign shift_en = !cs_ni && (state_q == ST_CFG);

  cfg_shift #(.W(CW)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cs_ni),
    .en_i   (shift_en),
    .bit_i  (di_i),
    .word_o (cfg_word),
    .last_o (cfg_last)
  );

  mux_decode #(.N(N)) u_dec (
    .cfg_i (cfg_word),
    .pos_o (dec_pos),
    .neg_o (dec_neg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b0;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      pos_q   <= '0;
      neg_q   <= '0;
    end else begin
      cs_q <= cs_ni;
      if (cs_ni) begin
        state_q <= ST_IDLE;
        pend_q  <= 1'b0;
        start_q <= 1'b0;
        pos_q   <= '0;
        neg_q   <= '0;
      end else begin
        start_q <= pend_q;
        pend_q  <= 1'b0;
        unique case (state_q)
          ST_IDLE: if (cs_q) state_q <= di_i ? ST_CFG : ST_HUNT;
          ST_HUNT: if (di_i) state_q <= ST_CFG;
          ST_CFG: begin
            if (cfg_last) begin
              pos_q   <= dec_pos;
              neg_q   <= dec_neg;
              pend_q  <= 1'b1;
              state_q <= ST_HOLD;
            end
          end
          ST_HOLD: ;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign pos_sel_o    = pos_q;
  assign neg_sel_o    = neg_q;
  assign conv_start_o = start_q;
endmodule

// File: rtl/adc_cfg_port_chk.sv
module adc_cfg_port_chk #(
  parameter int N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cs_ni,
  input logic [N-1:0] pos_sel_o,
  input logic [N:0]   neg_sel_o,
  input logic         conv_start_o
);
  assert_pos_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pos_sel_o));

  assert_neg_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(neg_sel_o));

  assert_no_overlap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_sel_o & neg_sel_o[N-1:0]) == '0);

  assert_cs_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (pos_sel_o == '0 && neg_sel_o == '0 && !conv_start_o));

  assert_start_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  assert_start_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(|pos_sel_o) && !cs_ni) |=> conv_start_o);

  assert_start_has_sel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> (|pos_sel_o && |neg_sel_o));

  assert_sel_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pos_sel_o && !cs_ni) |=> ($stable(pos_sel_o) && $stable(neg_sel_o)));
endmodule

bind adc_cfg_port adc_cfg_port_chk #(.N(N)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_ni        (cs_ni),
  .pos_sel_o    (pos_sel_o),
  .neg_sel_o    (neg_sel_o),
  .conv_start_o (conv_start_o)
);

// File: tb/sim_adc_cfg_port.sv
module sim_adc_cfg_port;
  localparam int N    = 8;
  localparam int ID_W = $clog2(N);
  localparam int SW   = ID_W - 1;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cs_ni = 1'b0;
  logic         di_i = 1'b0;
  logic [N-1:0] pos_sel_o;
  logic [N:0]   neg_sel_o;
  logic         conv_start_o;

  int checks = 0;
  int errors = 0;
  int starts_seen = 0;
  int starts_exp = 0;
  logic [2*N:0] exp_q[$];

  always #2 clk_i = ~clk_i;

  adc_cfg_port #(.N(N)) u0 (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_ni        (cs_ni),
    .di_i         (di_i),
    .pos_sel_o    (pos_sel_o),
    .neg_sel_o    (neg_sel_o),
    .conv_start_o (conv_start_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: pop expected selects when the start pulse appears
  logic prev_start = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni && conv_start_o) begin
      starts_seen++;
      chk(!prev_start, "R6 pulse width", 1, 0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected start", 1, 0);
      end else begin
        logic [2*N:0] e;
        e = exp_q.pop_front();
        chk({pos_sel_o, neg_sel_o} == e, "R3/R4/R5 decode", 32'({pos_sel_o, neg_sel_o}), 32'(e));
      end
    end
    prev_start = rst_ni && conv_start_o;
  end

  task automatic send_bit(input bit b);
    di_i = b;
    @(negedge clk_i);
  endtask

  task automatic xact(input int zeros, input bit sgl, input bit odd, input int sel);
    logic [N-1:0] ep;
    logic [N:0]   en;
    logic [ID_W-1:0] pid, nid;
    pid = ID_W'((sel << 1) | int'(odd));
    nid = ID_W'((sel << 1) | int'(!odd));
    ep = '0; en = '0;
    ep[pid] = 1'b1;
    if (sgl) en[N] = 1'b1; else en[nid] = 1'b1;
    exp_q.push_back({ep, en});
    starts_exp++;
    cs_ni = 1'b0;
    for (int i = 0; i < zeros; i++) send_bit(1'b0);  // R2 leading zeros
    send_bit(1'b1);
    send_bit(sgl);
    send_bit(odd);
    for (int i = SW - 1; i >= 0; i--) send_bit(sel[i]);
    // R6: selects valid right after the capture edge, start not yet
    chk(pos_sel_o == ep && neg_sel_o == en, "R6 select timing", 32'({pos_sel_o, neg_sel_o}), 32'({ep, en}));
    chk(!conv_start_o, "R6 start early", 32'(conv_start_o), 0);
    // R7: more bits after configuration have no effect
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(~odd);
    send_bit(1'b1);
    chk(pos_sel_o == ep && neg_sel_o == en, "R7 held", 32'({pos_sel_o, neg_sel_o}), 32'({ep, en}));
    cs_ni = 1'b1;
    @(negedge clk_i);
    chk(pos_sel_o == '0 && neg_sel_o == '0 && !conv_start_o, "R8 clear", 32'({pos_sel_o, neg_sel_o}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // R1: chip select already low when reset is released
    cs_ni = 1'b0;
    di_i  = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(pos_sel_o == '0 && neg_sel_o == '0 && !conv_start_o, "R8 reset state", 32'({pos_sel_o, neg_sel_o}), 0);
    rst_ni = 1'b1;
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b0);
    chk(pos_sel_o == '0 && neg_sel_o == '0, "R1 no falling edge", 32'({pos_sel_o, neg_sel_o}), 0);
    cs_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R3 R4 R5: every mode/odd/select combination, varying leading zeros (R2)
    for (int s = 0; s < 2; s++)
      for (int o = 0; o < 2; o++)
        for (int k = 0; k < (1 << SW); k++)
          xact((s * 4 + o * 2 + k) % 5, bit'(s), bit'(o), k);

    // R8: partial configuration aborted by chip select, then a clean one
    cs_ni = 1'b0;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    cs_ni = 1'b1;
    @(negedge clk_i);
    chk(pos_sel_o == '0 && !conv_start_o, "R8 partial cleared", 32'(pos_sel_o), 0);
    xact(0, 1'b0, 1'b1, 1);
    xact(7, 1'b1, 1'b1, (1 << SW) - 1);

    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R6 missing start", 32'(exp_q.size()), 0);
    chk(starts_seen == starts_exp, "R6 start count", 32'(starts_seen), 32'(starts_exp));
    finish_run();
  end
endmodule